// File: doc/BRIEF.md
# Byte-Packing DMA Threshold FIFO

This block moves data from a byte-wide local producer toward memory through an external DMA engine. Incoming bytes are joined in a holding stage, low byte first, into 16-bit halfwords. Each complete halfword enters a four-entry queue. When the number of queued entries reaches a programmable threshold, the block raises a DMA request. The engine accepts the request and then drains halfwords through a simple read strobe. The head entry is always visible on the read data port.

A registered enable status gates the local side and locks the threshold setting. If the enable input is removed while a DMA transfer is in progress, that status stays set until the transfer has completed its reads. A 16-bit status word exposes the enable, request and ready flags, the raw threshold, both queue pointers, the fill count and the holding-stage flags. The DMA engine, the bus interface and the producer are outside the block.

Top module: `dma_pack_fifo`

## Requirements
- R1: After synchronous active-low reset, `status_o` is 0x0000, `ready_o` is 0 and `dma_req_o` is 0.
- R2: The first accepted byte becomes bits 7:0 and the second accepted byte becomes bits 15:8 of a halfword. That halfword is presented on `dma_data_o` in arrival order.
- R3: The fill count (status bits 4:2) ranges over 0..4. `ready_o` (status bit 13) is 1 only when the enable status is set and fewer than 4 entries are queued. Bytes offered while `ready_o` is 0 are dropped.
- R4: The effective threshold equals the 3-bit threshold field, except that any value above 4 is used as 4. A field value of 0 never produces a request.
- R5: The request status (bit 14) is 1 when the effective threshold is nonzero and fill count ≥ effective threshold. `dma_req_o` is the same condition forced to 0 while `dma_tc_i` is 1. The status bit ignores `dma_tc_i`.
- R6: The enable status (bit 15) takes the value of `enable_i` one cycle later. While a transfer is active it stays at 1 and clears on the edge of the transfer's last read.
- R7: A transfer starts when `dma_ack_i` is high together with `dma_req_o`. It ends after as many successful reads as the effective threshold held at the start.
- R8: A threshold write (`thr_wr_i`) updates status bits 12:10 only while the enable status is 0. At other times it is ignored.
- R9: The write pointer (status bits 1:0) advances by one, modulo 4, for each halfword entering the queue. The read pointer (bits 9:8) advances by one, modulo 4, for each successful read.
- R10: Status bit 5 is 1 while the holding stage holds one byte. Bit 6 is 1 while it holds a complete halfword. When the queue has room, a complete halfword stays there exactly one cycle.
- R11: A read (`dma_rd_i`) with an empty queue changes nothing. A halfword entering the queue in the same cycle as a read leaves the fill count unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| enable_i | input | 1 | Block enable request |
| thr_wr_i | input | 1 | Threshold write strobe |
| thr_data_i | input | 3 | Threshold value to write |
| byte_valid_i | input | 1 | Local byte offered |
| byte_data_i | input | 8 | Local byte value |
| ready_o | output | 1 | Local side may offer bytes |
| dma_tc_i | input | 1 | Terminal count, masks the request output |
| dma_ack_i | input | 1 | DMA engine accepts the request |
| dma_rd_i | input | 1 | Read strobe, pops the head halfword |
| dma_req_o | output | 1 | DMA request |
| dma_data_o | output | 16 | Head halfword of the queue |
| status_o | output | 16 | Status word: 15 enable, 14 request, 13 ready, 12:10 threshold, 9:8 read pointer, 7 zero, 6 holding full, 5 byte present, 4:2 fill, 1:0 write pointer |

## Verification
Two functions can act on the same edge: the holding stage passes a finished halfword into the queue, and the DMA side pops the head. The bench provokes this by queueing one halfword and offering two bytes. It then asserts the read strobe in exactly the cycle in which the holding-full flag is up. It expects the fill count to stay the same, the read pointer and write pointer each to move by one, and the new head to be the packed pair. A second overlap is the last read of a transfer while `enable_i` is already low. The bench judges it by the enable status staying at 1 through each earlier read and reading 0 right after the last one.

// File: rtl/dpf_pkg.sv
// Package: shared status layout and threshold clamp for the byte-packing DMA FIFO.
// Assumes a four-entry queue, so pointers are 2 bits and the fill count is 3 bits.
package dpf_pkg;

    typedef struct packed {
        logic       en;
        logic       req;
        logic       rdy;
        logic [2:0] thr;
        logic [1:0] rd_ptr;
        logic       spare;
        logic       hold_full;
        logic       byte_pres;
        logic [2:0] fill;
        logic [1:0] wr_ptr;
    } dpf_status_t;

    // Any value above the queue depth is used as the depth.
    function automatic logic [2:0] clamp_thr(input logic [2:0] raw, input logic [2:0] depth);
        return (raw > depth) ? depth : raw;
    endfunction

endpackage

// File: rtl/dpf_packer.sv
// Module: holding stage that joins two bytes into one halfword, low byte first.
// Assumes the caller grants accept_en only when the queue has room. A full
// halfword leaves for the queue on the first edge on which space_i is high.
module dpf_packer #(
    parameter int BYTE_W = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                in_valid,
    input  logic [BYTE_W-1:0]   in_byte,
    input  logic                accept_en,
    input  logic                space_i,
    output logic                move_o,
    output logic [2*BYTE_W-1:0] hw_data_o,
    output logic                byte_pres_o,
    output logic                hold_full_o
);

    logic [BYTE_W-1:0] lo_q;
    logic [BYTE_W-1:0] hi_q;
    logic              have_lo_q;
    logic              full_q;
    logic              take;

    // Move the held pair out when the queue has room; take a byte when permitted.
    always_comb begin
        move_o = full_q && space_i;
        take   = in_valid && accept_en && !(full_q && !space_i);
    end

    // Track the holding-stage contents and flags.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lo_q      <= '0;
            hi_q      <= '0;
            have_lo_q <= 1'b0;
            full_q    <= 1'b0;
        end else begin
            if (move_o) begin
                full_q <= 1'b0;
            end
            if (take) begin
                if (have_lo_q) begin
                    hi_q      <= in_byte;
                    have_lo_q <= 1'b0;
                    full_q    <= 1'b1;
                end else begin
                    lo_q      <= in_byte;
                    have_lo_q <= 1'b1;
                end
            end
        end
    end

    assign hw_data_o   = {hi_q, lo_q};
    assign byte_pres_o = have_lo_q;
    assign hold_full_o = full_q;

endmodule

// File: rtl/dpf_queue.sv
// Module: circular halfword queue with a head that falls through to the output.
// Assumes DEPTH is a power of two. A push when full and a pop when empty are
// both ignored. A push and a pop on the same edge are both carried out.
module dpf_queue #(
    parameter int WIDTH = 16,
    parameter int DEPTH = 4,
    localparam int PTR_W = $clog2(DEPTH),
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic [WIDTH-1:0] wdata,
    input  logic             pop,
    output logic [WIDTH-1:0] rdata,
    output logic             push_ok,
    output logic             pop_ok,
    output logic [PTR_W-1:0] wr_ptr,
    output logic [PTR_W-1:0] rd_ptr,
    output logic [CNT_W-1:0] fill
);

    logic [WIDTH-1:0] slot_q [DEPTH];

    // Qualify the requests against the current occupancy.
    always_comb begin
        push_ok = push && (fill < CNT_W'(DEPTH));
        pop_ok  = pop && (fill != '0);
    end

    // One storage register per entry, loaded when the write pointer selects it.
    for (genvar i = 0; i < DEPTH; i++) begin : g_slot
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                slot_q[i] <= '0;
            end else if (push_ok && (wr_ptr == PTR_W'(i))) begin
                slot_q[i] <= wdata;
            end
        end
    end

    // Advance the pointers and the occupancy count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            fill   <= '0;
        end else begin
            if (push_ok) begin
                wr_ptr <= wr_ptr + PTR_W'(1);
            end
            if (pop_ok) begin
                rd_ptr <= rd_ptr + PTR_W'(1);
            end
            case ({push_ok, pop_ok})
                2'b10:   fill <= fill + CNT_W'(1);
                2'b01:   fill <= fill - CNT_W'(1);
                default: fill <= fill;
            endcase
        end
    end

    assign rdata = slot_q[rd_ptr];

endmodule

// File: rtl/dpf_xfer_ctl.sv
// Module: threshold register, request logic, transfer tracking and enable status.
// Assumes pop_ok marks successful reads. A read on the same edge that
// starts a transfer is not counted toward that transfer.
module dpf_xfer_ctl #(
    parameter int DEPTH = 4,
    parameter int THR_W = 3,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable_i,
    input  logic             thr_wr_i,
    input  logic [THR_W-1:0] thr_data_i,
    input  logic [CNT_W-1:0] fill,
    input  logic             pop_ok,
    input  logic             dma_ack_i,
    input  logic             dma_tc_i,
    output logic [THR_W-1:0] thr_q,
    output logic             req_stat,
    output logic             dma_req_o,
    output logic             en_q,
    output logic             active_q
);

    logic [THR_W-1:0] thr_eff;
    logic [THR_W-1:0] left_q;
    logic             start;
    logic             last;
    logic             active_nx;

    // Effective threshold, request condition and transfer boundaries.
    always_comb begin
        thr_eff   = dpf_pkg::clamp_thr(thr_q, THR_W'(DEPTH));
        req_stat  = (thr_eff != '0) && (THR_W'(fill) >= thr_eff);
        dma_req_o = req_stat && !dma_tc_i;
        start     = !active_q && dma_ack_i && dma_req_o;
        last      = active_q && pop_ok && (left_q == THR_W'(1));
        if (start) begin
            active_nx = 1'b1;
        end else if (last) begin
            active_nx = 1'b0;
        end else begin
            active_nx = active_q;
        end
    end

    // Transfer state: active flag and remaining read count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active_q <= 1'b0;
            left_q   <= '0;
        end else begin
            active_q <= active_nx;
            if (start) begin
                left_q <= thr_eff;
            end else if (active_q && pop_ok) begin
                left_q <= left_q - THR_W'(1);
            end
        end
    end

    // Enable status follows the input but holds while a transfer runs.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q <= 1'b0;
        end else begin
            en_q <= enable_i || active_nx;
        end
    end

    // Threshold register, writable only while the enable status is clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            thr_q <= '0;
        end else if (thr_wr_i && !en_q) begin
            thr_q <= thr_data_i;
        end
    end

endmodule

// File: rtl/dma_pack_fifo.sv
// Module: top of the byte-packing DMA threshold FIFO.
// Connects the packer, the queue and the transfer control, and assembles
// the status word. The status layout assumes BYTE_W = 8, DEPTH = 4 and THR_W = 3.
module dma_pack_fifo #(
    parameter int BYTE_W = 8,
    parameter int DEPTH  = 4,
    parameter int THR_W  = 3,
    localparam int HW_W  = 2 * BYTE_W,
    localparam int PTR_W = $clog2(DEPTH),
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enable_i,
    input  logic              thr_wr_i,
    input  logic [THR_W-1:0]  thr_data_i,
    input  logic              byte_valid_i,
    input  logic [BYTE_W-1:0] byte_data_i,
    output logic              ready_o,
    input  logic              dma_tc_i,
    input  logic              dma_ack_i,
    input  logic              dma_rd_i,
    output logic              dma_req_o,
    output logic [HW_W-1:0]   dma_data_o,
    output logic [15:0]       status_o
);

    logic [HW_W-1:0]  hw_data;
    logic             move;
    logic             byte_pres;
    logic             hold_full;
    logic             push_ok;
    logic             pop_ok;
    logic [PTR_W-1:0] wr_ptr;
    logic [PTR_W-1:0] rd_ptr;
    logic [CNT_W-1:0] fill;
    logic [THR_W-1:0] thr_q;
    logic             req_stat;
    logic             en_q;
    logic             active_q;
    logic             space;
    dpf_pkg::dpf_status_t st;

    // Queue room and local-side readiness.
    always_comb begin
        space   = fill < CNT_W'(DEPTH);
        ready_o = en_q && space;
    end

    dpf_packer #(.BYTE_W(BYTE_W)) u_pack (
        .clk         (clk),
        .rst_n       (rst_n),
        .in_valid    (byte_valid_i),
        .in_byte     (byte_data_i),
        .accept_en   (ready_o),
        .space_i     (space),
        .move_o      (move),
        .hw_data_o   (hw_data),
        .byte_pres_o (byte_pres),
        .hold_full_o (hold_full)
    );

    dpf_queue #(.WIDTH(HW_W), .DEPTH(DEPTH)) u_queue (
        .clk     (clk),
        .rst_n   (rst_n),
        .push    (move),
        .wdata   (hw_data),
        .pop     (dma_rd_i),
        .rdata   (dma_data_o),
        .push_ok (push_ok),
        .pop_ok  (pop_ok),
        .wr_ptr  (wr_ptr),
        .rd_ptr  (rd_ptr),
        .fill    (fill)
    );

    dpf_xfer_ctl #(.DEPTH(DEPTH), .THR_W(THR_W)) u_ctl (
        .clk        (clk),
        .rst_n      (rst_n),
        .enable_i   (enable_i),
        .thr_wr_i   (thr_wr_i),
        .thr_data_i (thr_data_i),
        .fill       (fill),
        .pop_ok     (pop_ok),
        .dma_ack_i  (dma_ack_i),
        .dma_tc_i   (dma_tc_i),
        .thr_q      (thr_q),
        .req_stat   (req_stat),
        .dma_req_o  (dma_req_o),
        .en_q       (en_q),
        .active_q   (active_q)
    );

    // Assemble the status word.
    always_comb begin
        st.en        = en_q;
        st.req       = req_stat;
        st.rdy       = ready_o;
        st.thr       = 3'(thr_q);
        st.rd_ptr    = 2'(rd_ptr);
        st.spare     = 1'b0;
        st.hold_full = hold_full;
        st.byte_pres = byte_pres;
        st.fill      = 3'(fill);
        st.wr_ptr    = 2'(wr_ptr);
        status_o     = st;
    end

endmodule

// File: rtl/dpf_checker.sv
// Module: temporal checks on the byte-packing DMA FIFO, bound to its top.
module dpf_checker #(
    parameter int DEPTH = 4,
    parameter int THR_W = 3,
    localparam int PTR_W = $clog2(DEPTH),
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input logic             clk,
    input logic             rst_n,
    input logic [CNT_W-1:0] fill,
    input logic             ready_o,
    input logic             dma_req_o,
    input logic             dma_tc_i,
    input logic             req_stat,
    input logic             hold_full,
    input logic             en_q,
    input logic             active_q,
    input logic [THR_W-1:0] thr_q,
    input logic             push_ok,
    input logic             pop_ok,
    input logic [PTR_W-1:0] wr_ptr
);

    assert_fill_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
        fill <= CNT_W'(DEPTH));

    assert_no_ready_full_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (fill == CNT_W'(DEPTH)) |-> !ready_o);

    assert_req_needs_data_R4: assert property (@(posedge clk) disable iff (!rst_n)
        req_stat |-> (fill != '0));

    assert_tc_masks_R5: assert property (@(posedge clk) disable iff (!rst_n)
        dma_tc_i |-> !dma_req_o);

    assert_en_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        active_q |-> en_q);

    assert_thr_lock_R8: assert property (@(posedge clk) disable iff (!rst_n)
        en_q |=> $stable(thr_q));

    assert_wr_step_R9: assert property (@(posedge clk) disable iff (!rst_n)
        push_ok |=> (wr_ptr == PTR_W'($past(wr_ptr) + 1'b1)));

    assert_hold_drain_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (hold_full && (fill < CNT_W'(DEPTH))) |=> !hold_full);

    assert_fill_balance_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (push_ok && pop_ok) |=> $stable(fill));

endmodule

bind dma_pack_fifo dpf_checker #(.DEPTH(DEPTH), .THR_W(THR_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .fill      (fill),
    .ready_o   (ready_o),
    .dma_req_o (dma_req_o),
    .dma_tc_i  (dma_tc_i),
    .req_stat  (req_stat),
    .hold_full (hold_full),
    .en_q      (en_q),
    .active_q  (active_q),
    .thr_q     (thr_q),
    .push_ok   (push_ok),
    .pop_ok    (pop_ok),
    .wr_ptr    (wr_ptr)
);

// File: tb/dma_pack_fifo_tb.sv
module dma_pack_fifo_tb;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        enable_i = 1'b0;
    logic        thr_wr_i = 1'b0;
    logic [2:0]  thr_data_i = '0;
    logic        byte_valid_i = 1'b0;
    logic [7:0]  byte_data_i = '0;
    logic        ready_o;
    logic        dma_tc_i = 1'b0;
    logic        dma_ack_i = 1'b0;
    logic        dma_rd_i = 1'b0;
    logic        dma_req_o;
    logic [15:0] dma_data_o;
    logic [15:0] status_o;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;
    logic [15:0] model[$];
    int wp = 0;
    int rp = 0;

    dma_pack_fifo u_dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .enable_i     (enable_i),
        .thr_wr_i     (thr_wr_i),
        .thr_data_i   (thr_data_i),
        .byte_valid_i (byte_valid_i),
        .byte_data_i  (byte_data_i),
        .ready_o      (ready_o),
        .dma_tc_i     (dma_tc_i),
        .dma_ack_i    (dma_ack_i),
        .dma_rd_i     (dma_rd_i),
        .dma_req_o    (dma_req_o),
        .dma_data_o   (dma_data_o),
        .status_o     (status_o)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    task automatic tick();
        @(posedge clk);
        #2;
    endtask

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic push_byte(input logic [7:0] b);
        byte_valid_i = 1'b1;
        byte_data_i  = b;
        tick();
        byte_valid_i = 1'b0;
    endtask

    task automatic push_pair(input logic [7:0] lo, input logic [7:0] hi);
        push_byte(lo);
        push_byte(hi);
        tick();
        model.push_back({hi, lo});
        wp = (wp + 1) % 4;
    endtask

    task automatic read_one(input string tag);
        chk(tag, int'(dma_data_o), int'(model[0]));
        dma_rd_i = 1'b1;
        tick();
        dma_rd_i = 1'b0;
        void'(model.pop_front());
        rp = (rp + 1) % 4;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) tick();
        // R1: reset state
        chk("R1 status", int'(status_o), 0);
        chk("R1 ready", int'(ready_o), 0);
        chk("R1 req", int'(dma_req_o), 0);
        rst_n = 1'b1;
        tick();

        for (int thr = 0; thr < 8; thr++) begin
            int eff;
            eff = (thr > 4) ? 4 : thr;
            enable_i = 1'b0;
            tick();
            tick();
            thr_wr_i = 1'b1;
            thr_data_i = 3'(thr);
            tick();
            thr_wr_i = 1'b0;
            chk("R8 write while disabled", int'(status_o[12:10]), thr);
            enable_i = 1'b1;
            tick();
            chk("R6 enable follows", int'(status_o[15]), 1);
            chk("R3 ready when enabled", int'(ready_o), 1);
            thr_wr_i = 1'b1;
            thr_data_i = 3'(thr ^ 5);
            tick();
            thr_wr_i = 1'b0;
            chk("R8 write ignored while enabled", int'(status_o[12:10]), thr);

            for (int k = 1; k <= 4; k++) begin
                push_pair(8'(thr * 16 + k * 2), 8'(8'hA0 + thr * 8 + k));
                chk("R3 fill", int'(status_o[4:2]), k);
                chk("R9 write pointer", int'(status_o[1:0]), wp);
                chk("R4 R5 request status", int'(status_o[14]), int'(eff != 0 && k >= eff));
                chk("R5 request output", int'(dma_req_o), int'(eff != 0 && k >= eff));
            end
            chk("R3 ready low when full", int'(ready_o), 0);
            chk("R3 status ready low", int'(status_o[13]), 0);
            push_byte(8'h55);
            chk("R3 byte dropped when full", int'(status_o[5]), 0);
            chk("R3 fill stays full", int'(status_o[4:2]), 4);

            dma_tc_i = 1'b1;
            #1;
            chk("R5 tc masks output", int'(dma_req_o), 0);
            chk("R5 tc leaves status", int'(status_o[14]), int'(eff != 0));
            dma_tc_i = 1'b0;
            #1;

            if (eff != 0) begin
                dma_ack_i = 1'b1;
                tick();
                dma_ack_i = 1'b0;
                enable_i = 1'b0;
                for (int i = 0; i < eff; i++) begin
                    read_one("R2 R7 transfer data");
                    chk("R9 read pointer", int'(status_o[9:8]), rp);
                    chk("R6 R7 enable held until last read", int'(status_o[15]), int'(i < eff - 1));
                end
            end else begin
                chk("R4 zero threshold never requests", int'(dma_req_o), 0);
            end
            while (model.size() > 0) begin
                read_one("R2 drain data");
                chk("R9 read pointer drain", int'(status_o[9:8]), rp);
            end
            chk("R3 fill empty", int'(status_o[4:2]), 0);
            dma_rd_i = 1'b1;
            tick();
            dma_rd_i = 1'b0;
            chk("R11 empty read fill", int'(status_o[4:2]), 0);
            chk("R11 empty read pointer", int'(status_o[9:8]), rp);
        end

        // Holding-stage flags and byte order.
        enable_i = 1'b1;
        tick();
        push_byte(8'h3C);
        chk("R10 byte present", int'(status_o[5]), 1);
        chk("R10 not full after one", int'(status_o[6]), 0);
        push_byte(8'hC3);
        chk("R10 holding full", int'(status_o[6]), 1);
        chk("R10 byte present clear", int'(status_o[5]), 0);
        tick();
        chk("R10 holding drained", int'(status_o[6]), 0);
        chk("R2 packed order", int'(dma_data_o), 16'hC33C);
        model.push_back(16'hC33C);
        wp = (wp + 1) % 4;
        chk("R3 fill one", int'(status_o[4:2]), 1);

        // Entry into queue and read on the same edge.
        push_byte(8'h12);
        push_byte(8'h34);
        chk("R11 holding full before overlap", int'(status_o[6]), 1);
        model.push_back(16'h3412);
        wp = (wp + 1) % 4;
        read_one("R11 head before overlap");
        chk("R11 fill unchanged", int'(status_o[4:2]), 1);
        chk("R11 write pointer moved", int'(status_o[1:0]), wp);
        chk("R11 read pointer moved", int'(status_o[9:8]), rp);
        chk("R2 new head", int'(dma_data_o), 16'h3412);
        read_one("R2 final drain");

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule